// File: doc/BRIEF.md
# Clock Post-Divider and Output Router

This block sits behind a frequency-synthesis loop. Its own clock is the loop's high-rate output, and it also takes a slower reference clock. From these it builds a primary clock output and an optional secondary clock output. The primary output is chosen from three sources:

- the loop clock divided by twice a programmable value,
- the reference clock as received,
- the reference clock divided by that same even ratio.

The secondary output is chosen from four sources:

- the reference clock,
- the reference clock halved,
- the primary output,
- the primary output halved.

Two preset banks hold the post-divide value and the primary source. The configuration is held on static input ports.

A single multi-function pin is given exactly one role by configuration:

- an enable input,
- a sleep (power-down) input,
- a bank-select input,
- the driver of the secondary clock.

The pin is sampled through a two-stage synchronizer. That synchronizer resets to 1, so a pin left high gives the default state: enabled, awake, bank A. A bank change or an enable change is applied only while the primary source is low, so no shortened high pulse reaches the output. A configuration bit decides whether a silenced primary output floats or is driven low.

Top module: `clk_post_router`

## Requirements
- R1: With the loop divider as source, the primary output stays high for P loop-clock cycles and then low for P cycles, where P is the active bank's post-divide value.
- R2: A post-divide value of 0 acts as 1, giving runs of one cycle.
- R3: The primary source code selects the output:
  - 0 or 3: loop clock divided by 2P.
  - 1: reference clock, runs equal to the reference half period.
  - 2: reference clock divided by 2P, runs of P reference periods.
- R4: The secondary source code selects the output:
  - 0: reference clock.
  - 1: reference clock halved.
  - 2: a delayed copy of the primary output.
  - 3: the primary output halved.
- R5: Pin role codes are 0 enable, 1 sleep, 2 bank select and 3 secondary output. Only in role 3 is `mfp_oe` high. In every other role `mfp_oe` and `mfp_o` stay 0.
- R6: In the enable role, a low pin silences the primary output at its next low phase. Returning the pin high restores the correct waveform.
- R7: In the sleep role, a low pin forces the primary output low two cycles after the pin changes. It also clears every divider, so after release the first high run has full length.
- R8: In the bank-select role, a high pin selects bank A and a low pin selects bank B, live, with no reset.
- R9: While the primary output is silenced, `pri_o` is 0 and `pri_oe` equals the inverse of `cfg_hiz`. While it is running, `pri_oe` is 1.
- R10: Across bank switches, enable toggles and sleep release, no high run on the primary output is shorter than the smaller active P.
- R11: After reset the primary output is 0 and enabled, and the pin reads as 1, so bank A is in use.
- R12: Reference-derived divisions count rising edges of the reference, which is sampled on the loop clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop high-rate clock, clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| mfp_in | input | 1 | Multi-function pin input level |
| cfg_p_a | input | PW | Post-divide value, bank A |
| cfg_p_b | input | PW | Post-divide value, bank B |
| cfg_src0_a | input | 2 | Primary source code, bank A |
| cfg_src0_b | input | 2 | Primary source code, bank B |
| cfg_src1 | input | 2 | Secondary source code |
| cfg_mode | input | 2 | Multi-function pin role |
| cfg_hiz | input | 1 | 1: silenced primary floats; 0: driven low |
| pri_o | output | 1 | Primary clock data |
| pri_oe | output | 1 | Primary driver enable |
| mfp_o | output | 1 | Secondary clock data on the pin |
| mfp_oe | output | 1 | Pin driver enable |

## Verification
The timing of each output is set by a fixed number of registers:

- The pin synchronizer adds two edges.
- The sleep role therefore acts on `pri_o` two cycles after a pin change.
- Enable and bank changes then wait for the next low phase of the source, which takes up to 2P+3 cycles.
- Reference waveforms lag the reference by three edges.

Because of these delays, the bench never checks a waveform at a fixed cycle. It waits a settling window scaled to the expected run length, discards the first partial run, and then compares four complete high and low runs with the length computed from P, the source code and the reference half period. Silenced states are checked only after a wait longer than the worst-case boundary delay. A negedge monitor records any high run shorter than the allowed minimum while changes are applied.

// File: rtl/clk_post_router.sv
module clk_post_router #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          mfp_in,
  input  logic [PW-1:0] cfg_p_a,
  input  logic [PW-1:0] cfg_p_b,
  input  logic [1:0]    cfg_src0_a,
  input  logic [1:0]    cfg_src0_b,
  input  logic [1:0]    cfg_src1,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_hiz,
  output logic          pri_o,
  output logic          pri_oe,
  output logic          mfp_o,
  output logic          mfp_oe
);
  localparam logic [1:0] ROLE_EN = 2'd0;
  localparam logic [1:0] ROLE_SLP = 2'd1;
  localparam logic [1:0] ROLE_BSEL = 2'd2;
  localparam logic [1:0] ROLE_CK = 2'd3;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [1:0] ref_sy, pin_sy;
  logic ref_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_sy <= '0;
      ref_d  <= 1'b0;
      pin_sy <= '1;
    end else begin
      ref_sy <= {ref_sy[0], ref_in};
      ref_d  <= ref_sy[1];
      pin_sy <= {pin_sy[0], mfp_in};
    end

  wire ref_s    = ref_sy[1];
  wire ref_rise = ref_s & ~ref_d;
  wire pin_s    = pin_sy[1];
  wire awake    = !(cfg_mode == ROLE_SLP && !pin_s);
  wire want_en  = !(cfg_mode == ROLE_EN && !pin_s);
  wire want_b   = (cfg_mode == ROLE_BSEL) && !pin_s;

  logic bank_q, en_q;
  wire [PW-1:0] p_sel = bank_q ? cfg_p_b : cfg_p_a;
  wire [PW-1:0] plim  = (p_sel == '0) ? ONE : p_sel;
  wire [1:0]    src0  = bank_q ? cfg_src0_b : cfg_src0_a;

  logic [PW-1:0] lcnt, rcnt;
  logic ldiv_q, rdiv_q, rhalf_q, c0half_q, c0_d, pri_q, sec_q;
  logic c0, c1;

  always_comb
    case (src0)
      2'd1:    c0 = ref_s;
      2'd2:    c0 = rdiv_q;
      default: c0 = ldiv_q;
    endcase

  always_comb
    case (cfg_src1)
      2'd0:    c1 = ref_s;
      2'd1:    c1 = rhalf_q;
      2'd2:    c1 = pri_q;
      default: c1 = c0half_q;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank_q <= 1'b0;
      en_q   <= 1'b1;
    end else if (!c0) begin
      bank_q <= want_b;
      en_q   <= want_en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !awake) begin
      lcnt     <= '0;
      rcnt     <= '0;
      ldiv_q   <= 1'b0;
      rdiv_q   <= 1'b0;
      rhalf_q  <= 1'b0;
      c0half_q <= 1'b0;
      c0_d     <= 1'b0;
      pri_q    <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      if (lcnt >= plim - ONE) begin
        lcnt   <= '0;
        ldiv_q <= ~ldiv_q;
      end else begin
        lcnt <= lcnt + ONE;
      end
      if (ref_rise) begin
        rhalf_q <= ~rhalf_q;
        if (rcnt >= plim - ONE) begin
          rcnt   <= '0;
          rdiv_q <= ~rdiv_q;
        end else begin
          rcnt <= rcnt + ONE;
        end
      end
      c0_d <= c0;
      if (c0 && !c0_d) c0half_q <= ~c0half_q;
      pri_q <= en_q ? c0 : 1'b0;
      sec_q <= c1;
    end

  assign pri_o  = pri_q & awake;
  assign pri_oe = (en_q & awake) | ~cfg_hiz;
  assign mfp_oe = (cfg_mode == ROLE_CK);
  assign mfp_o  = mfp_oe & sec_q;

  // R6
  en_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !pri_q);

  // R10
  bank_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> !$past(c0));

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> !pri_q);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bank_q) |-> lcnt < plim);
endmodule

// File: tb/clk_post_router_test.sv
module clk_post_router_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, mfp_in = 1'b1;
  logic [3:0] cfg_p_a = 4'd3, cfg_p_b = 4'd5;
  logic [1:0] cfg_src0_a = 2'd0, cfg_src0_b = 2'd0, cfg_src1 = 2'd0, cfg_mode = 2'd2;
  logic cfg_hiz = 1'b1;
  logic pri_o, pri_oe, mfp_o, mfp_oe;
  int errors = 0, checks = 0, hper = 3, mon_min = 0;
  bit runt_seen = 0, done = 0;

  clk_post_router #(.PW(4)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mfp_in(mfp_in),
    .cfg_p_a(cfg_p_a), .cfg_p_b(cfg_p_b), .cfg_src0_a(cfg_src0_a),
    .cfg_src0_b(cfg_src0_b), .cfg_src1(cfg_src1), .cfg_mode(cfg_mode),
    .cfg_hiz(cfg_hiz), .pri_o(pri_o), .pri_oe(pri_oe), .mfp_o(mfp_o), .mfp_oe(mfp_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  always begin
    repeat (hper) @(negedge clk);
    ref_in = ~ref_in;
  end

  int hr = 0;
  logic mprev = 1'b0;
  always @(negedge clk) begin
    if (pri_o && !mprev) hr = 1;
    else if (pri_o) hr++;
    else if (mprev && mon_min > 0 && hr < mon_min) runt_seen = 1;
    mprev = pri_o;
  end

  function automatic int run0(input int src, input int p, input int h);
    int pl = (p == 0) ? 1 : p;
    case (src)
      1: return h;
      2: return 2 * pl * h;
      default: return pl;
    endcase
  endfunction

  function automatic int run1(input int s1, input int src, input int p, input int h);
    case (s1)
      0: return h;
      1: return 2 * h;
      2: return run0(src, p, h);
      default: return 2 * run0(src, p, h);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runs(input bit which, input int exp, input string req);
    int run = 1, seen = -1, bad = -1;
    logic prev, cur;
    repeat (2 * exp + 10) @(negedge clk);
    prev = which ? mfp_o : pri_o;
    for (int i = 0; i < 20 * exp + 60 && seen < 4; i++) begin
      @(negedge clk);
      cur = which ? mfp_o : pri_o;
      if (cur == prev) run++;
      else begin
        if (seen >= 0 && run != exp && bad < 0) bad = run;
        seen++;
        run = 1;
      end
      prev = cur;
    end
    chk(seen >= 4 && bad < 0, req, (seen < 4) ? 0 : ((bad < 0) ? exp : bad), exp);
  endtask

  task automatic quiet(input int n, input bit exp_oe, input string req);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pri_o !== 1'b0 || pri_oe !== exp_oe) ok = 0;
    end
    chk(ok, req, {pri_o, pri_oe}, {1'b0, exp_oe});
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4711);
    bit ok;
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk(pri_o == 1'b0 && pri_oe == 1'b1, "R11", {pri_o, pri_oe}, 1);
    // R5 pin not driven in select role
    ok = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mfp_oe !== 1'b0 || mfp_o !== 1'b0) ok = 0;
    end
    chk(ok, "R5", {mfp_oe, mfp_o}, 0);
    // R11 default bank A, R1
    runs(0, 3, "R11");
    mon_min = 3;
    mfp_in = 1'b0;
    runs(0, 5, "R8");
    mfp_in = 1'b1;
    runs(0, 3, "R8");
    chk(!runt_seen, "R10", runt_seen, 0);
    mon_min = 0;

    // R2 zero divide value
    cfg_p_a = 4'd0;
    do_reset();
    runs(0, 1, "R2");

    // R6 / R9 enable role, floating when off
    cfg_mode = 2'd0; cfg_p_a = 4'd4; cfg_hiz = 1'b1;
    do_reset();
    runt_seen = 0; mon_min = 4;
    runs(0, 4, "R1");
    mfp_in = 1'b0;
    repeat (2 * 4 + 6) @(negedge clk);
    quiet(16, 1'b0, "R6");
    mfp_in = 1'b1;
    runs(0, 4, "R6");
    chk(!runt_seen, "R10", runt_seen, 0);
    cfg_hiz = 1'b0;
    mfp_in = 1'b0;
    repeat (2 * 4 + 6) @(negedge clk);
    quiet(16, 1'b1, "R9");
    mfp_in = 1'b1;
    mon_min = 0;

    // R7 sleep role
    cfg_mode = 2'd1; cfg_p_a = 4'd6; cfg_hiz = 1'b0;
    do_reset();
    runs(0, 6, "R7");
    mfp_in = 1'b0;
    repeat (4) @(negedge clk);
    quiet(20, 1'b1, "R7");
    cfg_hiz = 1'b1;
    @(negedge clk);
    quiet(5, 1'b0, "R9");
    runt_seen = 0; mon_min = 6;
    mfp_in = 1'b1;
    runs(0, 6, "R7");
    chk(!runt_seen, "R10", runt_seen, 0);
    mon_min = 0;

    // R12 reference divided by 2P
    cfg_mode = 2'd2; cfg_src0_a = 2'd2; cfg_p_a = 4'd3; hper = 3;
    do_reset();
    runs(0, 18, "R12");
    // R5 role 3 drives the pin
    cfg_mode = 2'd3; cfg_src1 = 2'd1;
    do_reset();
    @(negedge clk);
    chk(mfp_oe == 1'b1, "R5", mfp_oe, 1);
    runs(1, 6, "R4");

    // random mix, R3 and R4
    for (int it = 0; it < 8; it++) begin
      int p = $urandom % 16;
      int s0 = $urandom % 4;
      int s1 = $urandom % 4;
      int h = 2 + $urandom % 3;
      cfg_p_a = p[3:0]; cfg_src0_a = s0[1:0]; cfg_src1 = s1[1:0];
      cfg_mode = 2'd3; hper = h;
      do_reset();
      runs(0, run0(s0, p, h), "R3");
      runs(1, run1(s1, s0, p, h), "R4");
    end
    if (seed == 32'd0) $display("seed note");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule